// File: doc/BRIEF.md
# Double-Rate Prefetch Gearbox with Per-Byte Strobes

This block is the data-path gearbox between a wide core word and a narrow double-rate pin interface. On the write side it takes one word of four beats, with one mask bit per byte per beat, and plays it out as four consecutive half-cycle beats. It also drives a strobe whose edges fall in the middle of each beat, framed by a low preamble and a short postamble. On the read side it watches an incoming strobe per byte lane, takes one byte on every strobe transition and rebuilds the wide word. When the word is complete it raises a valid flag for one core cycle.

The model runs on a single fast clock at twice the core rate, so each pin beat lasts exactly one fast cycle. The write strobe is updated on the falling fast-clock edge to place its transitions mid-beat. On reads the strobe arrives edge-aligned with the data and is oversampled on the rising fast-clock edge. Each byte lane has its own strobe and mask. A parameter selects one or two byte lanes.

Top module: `ddr_prefetch_phy`

## Requirements
- R1: While reset is held and after its release, `dq_oe_o`, `dqs_oe_o`, every `dqs_o` bit and `rd_valid_o` are low.
- R2: In the two fast cycles after the edge that samples `wr_start_i` high, `dqs_oe_o` is 1, `dq_oe_o` is 0 and all `dqs_o` bits are 0. This is the one-core-cycle preamble.
- R3: In the four fast cycles after the preamble, `dq_oe_o` is 1 and beat b (b = 0..3) puts `wr_data_i[b*DQ_W +: DQ_W]` on `dq_o`. Lane l of that beat is bits `[b*DQ_W + l*8 +: 8]`, so the least significant slice goes first.
- R4: During write beat b, `dm_o[l]` equals `wr_mask_i[b*LANES + l]`. A 1 means the byte is not to be written, and the mask has the same timing as the data.
- R5: During write beat b, every `dqs_o` bit holds b[0] in the first half of the fast cycle and ~b[0] in the second half. The transition therefore falls in the middle of each beat, and `dq_o` does not change across it.
- R6: In the fast cycle after the last beat, `dqs_oe_o` is 1, `dq_oe_o` is 0 and `dqs_o` is 0. In the following cycle `dqs_oe_o` is 0.
- R7: On reads, each transition of `dqs_i[l]` captures `dq_i[l*8 +: 8]` as the next beat of lane l, starting at beat 0. The rebuilt word puts beat b of lane l at `rd_data_o[b*DQ_W + l*8 +: 8]`.
- R8: When every lane has captured four beats, `rd_valid_o` goes high one fast cycle after the last capture and stays high for exactly two fast cycles (one core cycle). `rd_data_o` is stable while it is high.
- R9: Byte lanes capture independently, so a word is rebuilt correctly when one lane's strobe is skewed by a fast cycle against the other's.
- R10: With `LANES` = 1 the bus is one byte wide (`DQ_W` = 8, word 32 bits), and writes and reads follow R3 and R7 on that lane alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock, twice the core rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_start_i | input | 1 | One-cycle pulse that starts a write burst |
| wr_data_i | input | 4*DQ_W | Write word, beat 0 in the low slice |
| wr_mask_i | input | 4*LANES | Per-beat, per-lane byte mask |
| dq_o | output | DQ_W | Data pins, output side |
| dm_o | output | LANES | Mask pins |
| dqs_o | output | LANES | Write strobe per lane |
| dq_oe_o | output | 1 | Data/mask pin output enable |
| dqs_oe_o | output | 1 | Strobe output enable |
| dq_i | input | DQ_W | Data pins, input side |
| dqs_i | input | LANES | Read strobe per lane, low when idle |
| rd_data_o | output | 4*DQ_W | Rebuilt read word |
| rd_valid_o | output | 1 | Read word valid, one core cycle |

## Verification
The assertions assume two things about the inputs. A new write pulse arrives only while the strobe driver is idle. Each read strobe rests low and toggles exactly four times per word, with the word's final capture happening after the previous valid window has closed. The bench keeps to both assumptions in the same way. It waits for each write burst to finish, including its postamble, before pulsing `wr_start_i` again. For reads it drives four alternating strobe levels per lane and returns every strobe low. It then idles for several cycles after the valid window before the next word.

// File: rtl/ddr_pf_pkg.sv
package ddr_pf_pkg;
  localparam int BYTE_W = 8;
  localparam int BEATS  = 4;

  typedef enum logic [1:0] {
    WS_IDLE,
    WS_PRE,
    WS_DATA,
    WS_POST
  } wr_state_e;
endpackage

// File: rtl/ddr_wr_serializer.sv
module ddr_wr_serializer
  import ddr_pf_pkg::*;
#(
  parameter int LANES = 2,
  localparam int DQ_W = LANES * BYTE_W,
  localparam int WORD_W = BEATS * DQ_W,
  localparam int MASK_W = BEATS * LANES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic [MASK_W-1:0] mask_i,
  output logic [DQ_W-1:0]   dq_o,
  output logic [LANES-1:0]  dm_o,
  output logic              dqs_o,
  output logic              dq_oe_o,
  output logic              dqs_oe_o
);
  wr_state_e         state_q;
  logic [1:0]        cnt_q;
  logic [WORD_W-1:0] data_q;
  logic [MASK_W-1:0] mask_q;
  logic              dqs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WS_IDLE;
      cnt_q   <= '0;
      data_q  <= '0;
      mask_q  <= '0;
    end else begin
      unique case (state_q)
        WS_IDLE: if (start_i) begin
          state_q <= WS_PRE;
          cnt_q   <= '0;
          data_q  <= data_i;
          mask_q  <= mask_i;
        end
        WS_PRE: begin
          cnt_q <= cnt_q + 2'd1;
          if (cnt_q == 2'd1) begin
            state_q <= WS_DATA;
            cnt_q   <= '0;
          end
        end
        WS_DATA: begin
          cnt_q  <= cnt_q + 2'd1;
          data_q <= data_q >> DQ_W;
          mask_q <= mask_q >> LANES;
          if (cnt_q == 2'd3) state_q <= WS_POST;
        end
        WS_POST: state_q <= WS_IDLE;
        default: state_q <= WS_IDLE;
      endcase
    end
  end

  // Falling-edge update puts strobe transitions mid-beat
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  dqs_q <= 1'b0;
    else if (state_q == WS_DATA)  dqs_q <= ~dqs_q;
    else                          dqs_q <= 1'b0;
  end

  assign dq_o     = data_q[DQ_W-1:0];
  assign dm_o     = mask_q[LANES-1:0];
  assign dqs_o    = dqs_q;
  assign dq_oe_o  = (state_q == WS_DATA);
  assign dqs_oe_o = (state_q != WS_IDLE);
endmodule

// File: rtl/ddr_rd_lane.sv
module ddr_rd_lane
  import ddr_pf_pkg::*;
#(
  localparam int LANE_W = BEATS * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              dqs_i,
  input  logic [BYTE_W-1:0] dq_i,
  output logic [LANE_W-1:0] beats_o,
  output logic              done_o
);
  logic       dqs_q;
  logic [1:0] cnt_q;
  logic       edge_s;

  assign edge_s = dqs_i ^ dqs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dqs_q   <= 1'b0;
      cnt_q   <= '0;
      beats_o <= '0;
      done_o  <= 1'b0;
    end else begin
      dqs_q <= dqs_i;
      if (clr_i) done_o <= 1'b0;
      if (edge_s) begin
        beats_o[cnt_q*BYTE_W +: BYTE_W] <= dq_i;
        cnt_q <= cnt_q + 2'd1;
        if (cnt_q == 2'd3) done_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ddr_prefetch_phy.sv
module ddr_prefetch_phy
  import ddr_pf_pkg::*;
#(
  parameter int LANES = 2,
  localparam int DQ_W = LANES * BYTE_W,
  localparam int WORD_W = BEATS * DQ_W,
  localparam int MASK_W = BEATS * LANES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_start_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic [MASK_W-1:0] wr_mask_i,
  output logic [DQ_W-1:0]   dq_o,
  output logic [LANES-1:0]  dm_o,
  output logic [LANES-1:0]  dqs_o,
  output logic              dq_oe_o,
  output logic              dqs_oe_o,
  input  logic [DQ_W-1:0]   dq_i,
  input  logic [LANES-1:0]  dqs_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              rd_valid_o
);
  localparam int LANE_W = BEATS * BYTE_W;

  logic                 wr_dqs;
  logic [LANES-1:0]     lane_done;
  logic [LANE_W-1:0]    lane_beats [LANES];
  logic [WORD_W-1:0]    word_s;
  logic                 all_done;
  logic [1:0]           vcnt_q;

  ddr_wr_serializer #(.LANES(LANES)) u_wr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (wr_start_i),
    .data_i   (wr_data_i),
    .mask_i   (wr_mask_i),
    .dq_o     (dq_o),
    .dm_o     (dm_o),
    .dqs_o    (wr_dqs),
    .dq_oe_o  (dq_oe_o),
    .dqs_oe_o (dqs_oe_o)
  );

  assign all_done = &lane_done;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign dqs_o[l] = wr_dqs;

    ddr_rd_lane u_rd (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (all_done),
      .dqs_i   (dqs_i[l]),
      .dq_i    (dq_i[l*BYTE_W +: BYTE_W]),
      .beats_o (lane_beats[l]),
      .done_o  (lane_done[l])
    );

    for (genvar b = 0; b < BEATS; b++) begin : g_beat
      assign word_s[b*DQ_W + l*BYTE_W +: BYTE_W] = lane_beats[l][b*BYTE_W +: BYTE_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vcnt_q    <= '0;
      rd_data_o <= '0;
    end else if (all_done) begin
      vcnt_q    <= 2'd2;
      rd_data_o <= word_s;
    end else if (vcnt_q != 2'd0) begin
      vcnt_q <= vcnt_q - 2'd1;
    end
  end

  assign rd_valid_o = (vcnt_q != 2'd0);
endmodule

// File: rtl/ddr_prefetch_phy_chk.sv
module ddr_prefetch_phy_chk
  import ddr_pf_pkg::*;
#(
  parameter int LANES = 2,
  localparam int DQ_W = LANES * BYTE_W,
  localparam int WORD_W = BEATS * DQ_W,
  localparam int MASK_W = BEATS * LANES
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_start_i,
  input logic [WORD_W-1:0] wr_data_i,
  input logic [MASK_W-1:0] wr_mask_i,
  input logic [DQ_W-1:0]   dq_o,
  input logic [LANES-1:0]  dm_o,
  input logic [LANES-1:0]  dqs_o,
  input logic              dq_oe_o,
  input logic              dqs_oe_o,
  input logic [DQ_W-1:0]   dq_i,
  input logic [LANES-1:0]  dqs_i,
  input logic [WORD_W-1:0] rd_data_o,
  input logic              rd_valid_o
);
  // Input rule: a write starts only while the strobe driver is idle
  a_r2_start_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_start_i |-> !dqs_oe_o);

  a_r2_preamble: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dqs_oe_o) |-> (!dq_oe_o && dqs_o == '0) ##1 (!dq_oe_o && dqs_o == '0));

  a_r3_data_framed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> dqs_oe_o);

  a_r3_four_beats: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dq_oe_o) |=> dq_oe_o ##1 dq_oe_o ##1 dq_oe_o ##1 !dq_oe_o);

  a_r6_postamble: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dq_oe_o) |-> (dqs_oe_o && dqs_o == '0) ##1 !dqs_oe_o);

  a_r8_valid_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_valid_o) |=> rd_valid_o ##1 !rd_valid_o);

  a_r8_data_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && $past(rd_valid_o)) |-> $stable(rd_data_o));

  a_r1_strobe_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dqs_oe_o |-> dqs_o == '0);
endmodule

bind ddr_prefetch_phy ddr_prefetch_phy_chk #(.LANES(LANES)) u_chk (.*);

// File: tb/ddr_prefetch_phy_test.sv
module ddr_prefetch_phy_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // wide instance, two lanes
  logic        wr_start = 1'b0;
  logic [63:0] wr_data = '0;
  logic [7:0]  wr_mask = '0;
  logic [15:0] dq_o;
  logic [1:0]  dm_o, dqs_o;
  logic        dq_oe, dqs_oe;
  logic [15:0] dq_i = '0;
  logic [1:0]  dqs_i = '0;
  logic [63:0] rd_data;
  logic        rd_valid;

  // narrow instance, one lane
  logic        n_start = 1'b0;
  logic [31:0] n_wdata = '0;
  logic [3:0]  n_wmask = '0;
  logic [7:0]  n_dq_o;
  logic [0:0]  n_dm_o, n_dqs_o;
  logic        n_dq_oe, n_dqs_oe;
  logic [7:0]  n_dq_i = '0;
  logic [0:0]  n_dqs_i = '0;
  logic [31:0] n_rdata;
  logic        n_valid;

  ddr_prefetch_phy #(.LANES(2)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_start_i(wr_start), .wr_data_i(wr_data),
    .wr_mask_i(wr_mask), .dq_o(dq_o), .dm_o(dm_o), .dqs_o(dqs_o),
    .dq_oe_o(dq_oe), .dqs_oe_o(dqs_oe), .dq_i(dq_i), .dqs_i(dqs_i),
    .rd_data_o(rd_data), .rd_valid_o(rd_valid)
  );

  ddr_prefetch_phy #(.LANES(1)) uut_n (
    .clk_i(clk), .rst_ni(rst_n), .wr_start_i(n_start), .wr_data_i(n_wdata),
    .wr_mask_i(n_wmask), .dq_o(n_dq_o), .dm_o(n_dm_o), .dqs_o(n_dqs_o),
    .dq_oe_o(n_dq_oe), .dqs_oe_o(n_dqs_oe), .dq_i(n_dq_i), .dqs_i(n_dqs_i),
    .rd_data_o(n_rdata), .rd_valid_o(n_valid)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [63:0] pat(input int i);
    logic [31:0] a, b;
    a = 32'(i) * 32'h9E37_79B1 + 32'h1357_2468;
    b = ~(32'(i) * 32'h85EB_CA77) ^ 32'hA5C3_0F96;
    return {a, b};
  endfunction

  task automatic wr_burst(input logic [63:0] d, input logic [7:0] m);
    @(negedge clk);
    wr_start = 1'b1; wr_data = d; wr_mask = m;
    @(posedge clk); #5;
    wr_start = 1'b0;
    for (int k = 0; k < 8; k++) begin
      if (k > 0) begin @(posedge clk); #5; end
      if (k < 2) begin
        chk(dqs_oe && !dq_oe && dqs_o == 2'b00, "R2 preamble",
            {61'd0, dqs_oe, dq_oe, |dqs_o}, 64'b100);
        #10;
        chk(dqs_o == 2'b00, "R2 preamble strobe low", 64'(dqs_o), 64'd0);
      end else if (k < 6) begin
        int b = k - 2;
        logic [15:0] exp_dq;
        logic [15:0] first_dq;
        exp_dq = d[b*16 +: 16];
        chk(dq_oe && dqs_oe, "R3 beat enable", {62'd0, dq_oe, dqs_oe}, 64'b11);
        chk(dq_o == exp_dq, "R3 beat data", 64'(dq_o), 64'(exp_dq));
        chk(dm_o == m[b*2 +: 2], "R4 beat mask", 64'(dm_o), 64'(m[b*2 +: 2]));
        chk(dqs_o == {2{b[0]}}, "R5 strobe first half", 64'(dqs_o), 64'({2{b[0]}}));
        first_dq = dq_o;
        #10;
        chk(dqs_o == {2{~b[0]}}, "R5 strobe second half", 64'(dqs_o), 64'({2{~b[0]}}));
        chk(dq_o == first_dq, "R5 data stable across strobe edge", 64'(dq_o), 64'(first_dq));
      end else if (k == 6) begin
        chk(dqs_oe && !dq_oe && dqs_o == 2'b00, "R6 postamble",
            {61'd0, dqs_oe, dq_oe, |dqs_o}, 64'b100);
        #10;
      end else begin
        chk(!dqs_oe && !dq_oe, "R6 strobe released", {62'd0, dqs_oe, dq_oe}, 64'd0);
        #10;
      end
    end
  endtask

  // drive four edge-aligned beats per lane, lane l delayed by sk[l] cycles
  task automatic rd_burst(input logic [63:0] d, input int s0, input int s1, input string req);
    int smax;
    int nvalid;
    int first;
    logic [63:0] got;
    smax = (s0 > s1) ? s0 : s1;
    for (int j = 0; j < 4 + smax; j++) begin
      @(negedge clk);
      for (int l = 0; l < 2; l++) begin
        int b = j - ((l == 0) ? s0 : s1);
        if (b >= 0 && b < 4) begin
          dq_i[l*8 +: 8] = d[b*16 + l*8 +: 8];
          dqs_i[l] = ~b[0];
        end else begin
          dq_i[l*8 +: 8] = 8'h00;
          dqs_i[l] = 1'b0;
        end
      end
    end
    nvalid = 0; first = -1; got = '0;
    for (int i = 0; i < 6; i++) begin
      @(posedge clk); #5;
      if (i == 0) begin dq_i = '0; dqs_i = '0; end
      if (rd_valid) begin
        nvalid++;
        if (first < 0) begin first = i; got = rd_data; end
      end
    end
    chk(first == 1, {req, " valid timing"}, 64'(first), 64'd1);
    chk(nvalid == 2, "R8 valid length", 64'(nvalid), 64'd2);
    chk(got == d, {req, " word"}, got, d);
  endtask

  initial begin
    #15;
    chk(!dq_oe && !dqs_oe && dqs_o == 2'b00 && !rd_valid, "R1 in reset",
        {60'd0, dq_oe, dqs_oe, |dqs_o, rd_valid}, 64'd0);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #5;
    chk(!dq_oe && !dqs_oe && dqs_o == 2'b00 && !rd_valid, "R1 after reset",
        {60'd0, dq_oe, dqs_oe, |dqs_o, rd_valid}, 64'd0);

    // every mask value, each with its own data word
    for (int m = 0; m < 256; m++) begin
      wr_burst(pat(m), 8'(m));
    end
    wr_burst(64'h0, 8'h00);
    wr_burst(64'hFFFF_FFFF_FFFF_FFFF, 8'hFF);

    for (int i = 0; i < 16; i++) begin
      rd_burst(pat(i + 300), 0, 0, "R7 aligned lanes");
      rd_burst(pat(i + 400), 1, 0, "R9 lane0 late");
      rd_burst(pat(i + 500), 0, 1, "R9 lane1 late");
    end

    // narrow build: write then read on a single lane
    begin
      logic [31:0] nd;
      int nv;
      logic [31:0] ng;
      nd = 32'hC3A5_5A3C;
      @(negedge clk);
      n_start = 1'b1; n_wdata = nd; n_wmask = 4'b1010;
      @(posedge clk); #5;
      n_start = 1'b0;
      @(posedge clk); #5;
      for (int b = 0; b < 4; b++) begin
        @(posedge clk); #5;
        chk(n_dq_oe && n_dq_o == nd[b*8 +: 8], "R10 narrow write beat",
            64'(n_dq_o), 64'(nd[b*8 +: 8]));
        chk(n_dm_o[0] == n_wmask[b], "R10 narrow mask", 64'(n_dm_o), 64'(n_wmask[b]));
      end
      repeat (3) @(posedge clk);
      nd = 32'h1E2D_3C4B;
      for (int b = 0; b < 4; b++) begin
        @(negedge clk);
        n_dq_i = nd[b*8 +: 8];
        n_dqs_i[0] = ~b[0];
      end
      nv = 0; ng = '0;
      for (int i = 0; i < 6; i++) begin
        @(posedge clk); #5;
        if (i == 0) begin n_dq_i = '0; n_dqs_i = '0; end
        if (n_valid) begin
          if (nv == 0) ng = n_rdata;
          nv++;
        end
      end
      chk(nv == 2 && ng == nd, "R10 narrow read word", 64'(ng), 64'(nd));
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule